// File: doc/BRIEF.md
# Predicated Vector Add Sequencer

This block expands one scalar add into a string of element adds over a 32-entry, 64-bit integer register file. The register file is inside the block. An issue handshake delivers a destination register, two source registers and a predicate register, along with three flags. Each flag marks one operand, destination or source, as vector or scalar. The vector length comes from a control-register input and is captured when the instruction is accepted. The block then performs one element per cycle. Element i adds the two source registers it selects and writes the destination it selects, but only when bit i of the predicate mask is set.

A vector operand steps its register number by one on every element, and the number wraps modulo 32. A scalar operand keeps the same register for the whole run. A single add path therefore covers scalar-scalar, scalar-vector and vector-vector forms without a separate opcode. While elements are being issued, the block raises a hold output that the front end uses to freeze its fetch counter. A one-cycle done pulse marks the end of each run.

A host port gives the surrounding scalar pipeline ordinary access to the register file while the block is idle. It can write one register per cycle and read one register combinationally.

Top module: `vec_add_seq`

## Requirements
- R1: `issue_ready_o` is high exactly when no run is in progress. An issue request presented while `hold_o` is high is ignored and changes no register.
- R2: An accepted add with vector length VL (0 to 63, taken from `vl_i` in the accept cycle) performs element operations for indices 0 to VL-1, one per cycle, in rising index order. Element i is performed in the i+1-th cycle after the accept edge, and its write is visible from the following cycle.
- R3: The predicate mask is the 64-bit content of register `pred_i`. Element i writes its destination only when bit i of that mask is 1.
- R4: When `rd_vec_i` is 1, element i writes register (`rd_i` + i). When it is 0, every element targets register `rd_i`.
- R5: Each source is handled independently. Element i reads register (`rs1_i` + i) when `rs1_vec_i` is 1 and `rs1_i` otherwise, and likewise for `rs2_i` with `rs2_vec_i`.
- R6: Register offsets advance on every element, including elements whose predicate bit is 0. A masked element performs no write.
- R7: With VL = 0, no register is written, `hold_o` never rises, and `done_o` is high in the first cycle after the accept edge.
- R8: For VL > 0, `hold_o` is high in exactly the VL cycles that follow the accept edge.
- R9: `done_o` is a one-cycle pulse in the cycle after the last element, and the block is ready again in that cycle.
- R10: A register number formed from a base plus an element offset wraps modulo 32.
- R11: The sum is taken modulo 2^64. Each element reads the register contents as they stood at the start of its cycle, so it observes the writes of earlier elements.
- R12: The predicate mask is captured once, in the accept cycle. A write by the run to the predicate register does not alter the mask for later elements.
- R13: A host write (`host_we_i`) lands at the next edge only while `hold_o` is low, and is ignored otherwise. While the block is idle and no issue is presented, `host_rdata_o` shows the register selected by `host_raddr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_valid_i | input | 1 | Add instruction presented |
| issue_ready_o | output | 1 | Block idle, instruction accepted this cycle if valid |
| rd_i | input | 5 | Destination base register |
| rs1_i | input | 5 | First source base register |
| rs2_i | input | 5 | Second source base register |
| pred_i | input | 5 | Register holding the element mask |
| rd_vec_i | input | 1 | Destination is a vector |
| rs1_vec_i | input | 1 | First source is a vector |
| rs2_vec_i | input | 1 | Second source is a vector |
| vl_i | input | 6 | Current vector length from the control register |
| hold_o | output | 1 | Elements in flight, fetch counter frozen |
| done_o | output | 1 | One-cycle end-of-run pulse |
| host_we_i | input | 1 | Host register write enable |
| host_waddr_i | input | 5 | Host write register |
| host_wdata_i | input | 64 | Host write data |
| host_raddr_i | input | 5 | Host read register |
| host_rdata_o | output | 64 | Host read data |

## Verification
The hardest behaviour to reach is the run that rewrites its own operands. This covers a destination range that covers the predicate register or later source elements, and a scalar destination that is also a scalar source. Only a stale mask or a stale operand read would show the difference. The stimulus builds these cases on purpose. One run zeroes the predicate register with its first element and then needs the later elements to survive. One wraps a vector destination through registers that a vector source reads three elements later. One accumulates into a single scalar register. Conflicting issue requests and host writes are injected while hold is high. The result is compared against a sequential reference model across the entire register file.

// File: rtl/vas_pkg.sv
package vas_pkg;
  localparam int unsigned NREG  = 32;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned VL_W  = 6;
  localparam int unsigned AW    = $clog2(NREG);
  localparam int unsigned NOPND = 3;  // 0: dest, 1: src1, 2: src2

  typedef logic [AW-1:0]   reg_idx_t;
  typedef logic [XLEN-1:0] xword_t;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

  typedef struct packed {
    reg_idx_t rd;
    reg_idx_t rs1;
    reg_idx_t rs2;
    logic     rd_vec;
    logic     rs1_vec;
    logic     rs2_vec;
  } vinst_t;
endpackage

// File: rtl/vas_regfile.sv
module vas_regfile #(
  parameter int unsigned NREG = vas_pkg::NREG,
  parameter int unsigned XLEN = vas_pkg::XLEN,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   ra_addr_i,
  output logic [XLEN-1:0] ra_data_o,
  input  logic [AW-1:0]   rb_addr_i,
  output logic [XLEN-1:0] rb_data_o,
  input  logic            we_i,
  input  logic [AW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] mem_q [NREG];

  // reads return start-of-cycle contents
  assign ra_data_o = mem_q[ra_addr_i];
  assign rb_data_o = mem_q[rb_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NREG); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wa_i] <= wd_i;
    end
  end
endmodule

// File: rtl/vas_opnd.sv
module vas_opnd #(
  parameter int unsigned AW   = vas_pkg::AW,
  parameter int unsigned IDXW = vas_pkg::VL_W
) (
  input  logic [AW-1:0]   base_i,
  input  logic            is_vec_i,
  input  logic [IDXW-1:0] idx_i,
  output logic [AW-1:0]   addr_o
);
  logic [AW-1:0] ofs;
  // truncation gives modulo-NREG wrap
  assign ofs    = is_vec_i ? AW'(idx_i) : '0;
  assign addr_o = base_i + ofs;
endmodule

// File: rtl/vas_ctrl.sv
module vas_ctrl #(
  parameter int unsigned VL_W = vas_pkg::VL_W,
  parameter int unsigned XLEN = vas_pkg::XLEN
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_valid_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic [XLEN-1:0] pred_val_i,
  output logic            ready_o,
  output logic            accept_o,
  output logic            run_o,
  output logic [VL_W-1:0] idx_o,
  output logic            elem_en_o,
  output logic            done_o
);
  import vas_pkg::*;

  seq_state_e      state_q;
  logic [VL_W-1:0] idx_q, vl_q;
  logic [XLEN-1:0] mask_q;
  logic            done_q;
  logic            last;

  assign ready_o   = (state_q == ST_IDLE);
  assign accept_o  = issue_valid_i & ready_o;
  assign run_o     = (state_q == ST_RUN);
  assign idx_o     = idx_q;
  assign last      = run_o && (idx_q == vl_q - VL_W'(1));
  assign elem_en_o = run_o & mask_q[idx_q];
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      vl_q    <= '0;
      mask_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        mask_q  <= pred_val_i;  // sampled once per run
        vl_q    <= vl_i;
        idx_q   <= '0;
        state_q <= (vl_i != '0) ? ST_RUN : ST_IDLE;
        done_q  <= (vl_i == '0);
      end else if (run_o) begin
        idx_q <= idx_q + VL_W'(1);
        if (last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vec_add_seq.sv
module vec_add_seq #(
  parameter int unsigned NREG = vas_pkg::NREG,
  parameter int unsigned XLEN = vas_pkg::XLEN,
  parameter int unsigned VL_W = vas_pkg::VL_W,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_valid_i,
  output logic            issue_ready_o,
  input  logic [AW-1:0]   rd_i,
  input  logic [AW-1:0]   rs1_i,
  input  logic [AW-1:0]   rs2_i,
  input  logic [AW-1:0]   pred_i,
  input  logic            rd_vec_i,
  input  logic            rs1_vec_i,
  input  logic            rs2_vec_i,
  input  logic [VL_W-1:0] vl_i,
  output logic            hold_o,
  output logic            done_o,
  input  logic            host_we_i,
  input  logic [AW-1:0]   host_waddr_i,
  input  logic [XLEN-1:0] host_wdata_i,
  input  logic [AW-1:0]   host_raddr_i,
  output logic [XLEN-1:0] host_rdata_o
);
  localparam int unsigned NOPND = vas_pkg::NOPND;

  logic            accept, run, elem_en;
  logic [VL_W-1:0] idx;
  logic [AW-1:0]   ra_addr, rb_addr, wa;
  logic [XLEN-1:0] ra_data, rb_data, wd;
  logic            we;
  logic [AW-1:0]   rd_q, rs1_q, rs2_q;
  logic            rd_vec_q, rs1_vec_q, rs2_vec_q;
  logic [AW-1:0]   base_a [NOPND];
  logic            vec_a  [NOPND];
  logic [AW-1:0]   addr_a [NOPND];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0; rs1_q <= '0; rs2_q <= '0;
      rd_vec_q <= 1'b0; rs1_vec_q <= 1'b0; rs2_vec_q <= 1'b0;
    end else if (accept) begin
      rd_q <= rd_i; rs1_q <= rs1_i; rs2_q <= rs2_i;
      rd_vec_q <= rd_vec_i; rs1_vec_q <= rs1_vec_i; rs2_vec_q <= rs2_vec_i;
    end
  end

  assign base_a[0] = rd_q;  assign vec_a[0] = rd_vec_q;
  assign base_a[1] = rs1_q; assign vec_a[1] = rs1_vec_q;
  assign base_a[2] = rs2_q; assign vec_a[2] = rs2_vec_q;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    vas_opnd #(.AW(AW), .IDXW(VL_W)) u_opnd (
      .base_i  (base_a[g]),
      .is_vec_i(vec_a[g]),
      .idx_i   (idx),
      .addr_o  (addr_a[g])
    );
  end

  vas_ctrl #(.VL_W(VL_W), .XLEN(XLEN)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_valid_i(issue_valid_i),
    .vl_i         (vl_i),
    .pred_val_i   (ra_data),
    .ready_o      (issue_ready_o),
    .accept_o     (accept),
    .run_o        (run),
    .idx_o        (idx),
    .elem_en_o    (elem_en),
    .done_o       (done_o)
  );

  // port A: src1 while running, predicate on accept, host read otherwise
  assign ra_addr = run ? addr_a[1] : (accept ? pred_i : host_raddr_i);
  assign rb_addr = addr_a[2];
  assign we      = run ? elem_en : host_we_i;
  assign wa      = run ? addr_a[0] : host_waddr_i;
  assign wd      = run ? (ra_data + rb_data) : host_wdata_i;

  vas_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ra_addr_i(ra_addr),
    .ra_data_o(ra_data),
    .rb_addr_i(rb_addr),
    .rb_data_o(rb_data),
    .we_i     (we),
    .wa_i     (wa),
    .wd_i     (wd)
  );

  assign hold_o       = run;
  assign host_rdata_o = ra_data;
endmodule

// File: rtl/vec_add_seq_chk.sv
module vec_add_seq_chk #(
  parameter int unsigned VL_W = vas_pkg::VL_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            issue_valid_i,
  input logic            issue_ready_o,
  input logic [VL_W-1:0] vl_i,
  input logic            hold_o,
  input logic            done_o
);
  // R1
  busy_blocks_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> !issue_ready_o);

  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!hold_o && issue_ready_o));

  // R8
  hold_end_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> done_o);

  // R8
  start_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_ready_o && vl_i != '0) |=> (hold_o && !done_o));

  // R7
  zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_ready_o && vl_i == '0) |=> (done_o && !hold_o));
endmodule

bind vec_add_seq vec_add_seq_chk #(.VL_W(VL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .issue_valid_i(issue_valid_i),
  .issue_ready_o(issue_ready_o),
  .vl_i         (vl_i),
  .hold_o       (hold_o),
  .done_o       (done_o)
);

// File: tb/vec_add_seq_tb.sv
module vec_add_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_valid_i = 1'b0;
  logic        issue_ready_o;
  logic [4:0]  rd_i = '0, rs1_i = '0, rs2_i = '0, pred_i = '0;
  logic        rd_vec_i = 1'b0, rs1_vec_i = 1'b0, rs2_vec_i = 1'b0;
  logic [5:0]  vl_i = '0;
  logic        hold_o, done_o;
  logic        host_we_i = 1'b0;
  logic [4:0]  host_waddr_i = '0, host_raddr_i = '0;
  logic [63:0] host_wdata_i = '0;
  logic [63:0] host_rdata_o;

  int checks = 0;
  int failures = 0;
  logic [63:0] m [32];

  typedef struct {int addr; logic [63:0] data; string req;} exp_t;
  exp_t sb_q[$];

  always #4 clk_i = ~clk_i;  // 125 MHz

  vec_add_seq u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input int a, input logic [63:0] d);
    @(negedge clk_i);
    host_we_i = 1'b1; host_waddr_i = 5'(a); host_wdata_i = d;
    @(negedge clk_i);
    host_we_i = 1'b0;
    m[a] = d;
  endtask

  // driver: runs the model, drives the issue, checks handshake timing, pushes expected state
  task automatic run_add(input int rd, input int rs1, input int rs2, input int pr,
                         input bit vr, input bit v1, input bit v2, input int vl,
                         input bit noise, input string req);
    logic [63:0] mask;
    mask = m[pr];
    for (int i = 0; i < vl; i++) begin
      int a1, a2, ad;
      a1 = (rs1 + (v1 ? i : 0)) % 32;
      a2 = (rs2 + (v2 ? i : 0)) % 32;
      ad = (rd + (vr ? i : 0)) % 32;
      if (mask[i]) m[ad] = m[a1] + m[a2];
    end
    @(negedge clk_i);
    rd_i = 5'(rd); rs1_i = 5'(rs1); rs2_i = 5'(rs2); pred_i = 5'(pr);
    rd_vec_i = vr; rs1_vec_i = v1; rs2_vec_i = v2; vl_i = 6'(vl);
    issue_valid_i = 1'b1;
    #1 chk(issue_ready_o == 1'b1, {"R1 ready before ", req}, 64'(issue_ready_o), 64'd1);
    for (int k = 1; k <= vl + 1; k++) begin
      @(negedge clk_i);
      if (k == 1) issue_valid_i = 1'b0;
      if (noise && vl >= 2 && k == 1) begin
        // conflicting issue and host write while busy: both must be dropped
        issue_valid_i = 1'b1; rd_i = 5'd23; rd_vec_i = 1'b1; pred_i = 5'd31;
        host_we_i = 1'b1; host_waddr_i = 5'd24; host_wdata_i = 64'hDEAD_0000_BEEF_0000;
      end
      if (noise && vl >= 2 && k == vl) begin
        issue_valid_i = 1'b0; host_we_i = 1'b0;
      end
      #1;
      chk(hold_o == (k <= vl), {"R8 hold window ", req}, 64'(hold_o), 64'(k <= vl));
      chk(done_o == (k == vl + 1), {"R9 done pulse ", req}, 64'(done_o), 64'(k == vl + 1));
      if (hold_o) chk(issue_ready_o == 1'b0, {"R1 busy ready ", req}, 64'(issue_ready_o), 64'd0);
    end
    issue_valid_i = 1'b0;
    for (int r = 0; r < 32; r++) sb_q.push_back('{r, m[r], req});
  endtask

  // monitor: pops expected register contents and compares via the host read port
  task automatic drain();
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      @(negedge clk_i);
      host_raddr_i = 5'(e.addr);
      #1 chk(host_rdata_o == e.data, $sformatf("%s r%0d", e.req, e.addr), host_rdata_o, e.data);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) m[r] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state (R1, R13)
    chk(issue_ready_o == 1'b1, "R1 reset ready", 64'(issue_ready_o), 64'd1);
    chk(hold_o == 1'b0, "R8 reset hold", 64'(hold_o), 64'd0);
    chk(done_o == 1'b0, "R9 reset done", 64'(done_o), 64'd0);
    for (int r = 0; r < 32; r++) sb_q.push_back('{r, 64'd0, "R13 reset contents"});
    drain();

    for (int r = 0; r < 32; r++) host_wr(r, 64'h0100_0000_0000_0000 * 64'(r) + 64'(r * 3 + 7));
    host_wr(30, '1);
    for (int r = 0; r < 32; r++) sb_q.push_back('{r, m[r], "R13 host write"});
    drain();

    // vector-vector with busy noise (R2 R5 R1 R13)
    run_add(8, 0, 16, 30, 1, 1, 1, 4, 1, "R2 R5 vv noise");
    drain();
    // scalar dest accumulating into scalar src (R4 R11)
    run_add(1, 1, 16, 30, 0, 0, 1, 5, 1, "R4 R11 accumulate");
    drain();
    // sparse mask 0xA5 (R3 R6)
    host_wr(29, 64'hA5);
    run_add(2, 16, 20, 29, 1, 1, 1, 8, 0, "R3 R6 mask");
    drain();
    // scalar-vector mix (R5)
    run_add(24, 5, 8, 30, 1, 0, 1, 3, 0, "R5 scalar src");
    drain();
    // predicate overwritten by own first element (R12)
    host_wr(20, 64'hF);
    host_wr(12, 64'd0); host_wr(4, 64'd0);
    run_add(20, 12, 4, 20, 0, 1, 0, 4, 0, "R12 mask once");
    drain();
    // wrap through 31 -> 0 (R10)
    host_wr(19, '1);
    run_add(29, 26, 3, 19, 1, 1, 0, 6, 1, "R10 wrap");
    drain();
    // zero length (R7)
    run_add(5, 6, 7, 30, 1, 1, 1, 0, 0, "R7 zero len");
    drain();
    // overflow (R11)
    host_wr(10, '1); host_wr(11, 64'd2);
    run_add(12, 10, 11, 30, 0, 0, 0, 1, 0, "R11 overflow");
    drain();
    // longest run with wrap and mixed mask (R2 R3 R10)
    host_wr(18, 64'h5A5A_F0F0_3C3C_9999);
    run_add(7, 0, 9, 18, 1, 1, 0, 63, 1, "R2 R10 max vl");
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule